// File: doc/BRIEF.md
# Dual-Issue Integer Vector ALU Pair

This block executes one paired vector instruction per clock across a small group of SIMD lanes. Each instruction carries two independent operations, called the X slot and the Y slot. Each lane owns a private bank of 32-bit registers. The block decodes both opcodes and rebuilds the full Y destination index from a shortened field. It samples every source operand of both slots from the register state as it stood before the instruction, and then commits both results in every lane that is enabled by the lane mask.

The X slot can only copy a value. The Y slot can also perform a wrapping add, a reverse-operand left shift and a bitwise AND. In each slot, the first source can take a 32-bit literal word that travels with the instruction instead of a register. An opcode outside a slot's legal range raises an error flag, and neither slot writes for that instruction. A peek port exposes one register index across all lanes. The bench uses it to observe the register state.

Top module: `dual_valu_pair`

## Requirements
- R1: Both slots read their sources from the register state before the instruction. When X writes a register that Y reads, Y uses the old value.
- R2: X opcode 0 is a copy. X opcodes 1 to 15 are reserved and write nothing. An X opcode of 16 or above raises `err` and suppresses the writes of both slots.
- R3: Y opcodes are as follows. 0 is a copy, 16 is a wrapping add, 17 is a reverse shift and 18 is AND. Opcodes 1 to 15 write nothing. A Y opcode of 19 or above raises `err` and suppresses the writes of both slots.
- R4: The Y destination index is `(dst_y_f << 1) | (~dst_x[0])`, so the two destinations always have opposite parity.
- R5: The Y add returns `(a + b) mod 2^32`. For example, 0xFFFFFFFF + 1 = 0.
- R6: The Y reverse shift returns `b << a[4:0]`. For example, a shift amount of 33 shifts by 1.
- R7: The Y AND returns `a & b`.
- R8: When `x_a_lit` or `y_a_lit` is 1, that slot's first source is the `literal` word instead of a register.
- R9: An instruction writes only in lanes whose `lane_en` bit is 1. Other lanes keep their values, and each lane computes from its own registers.
- R10: `in_ready` is 1 outside reset. An accepted instruction is visible on `peek_data` after the accepting edge. `err` is high only in the cycle after an accepted illegal instruction.
- R11: Reset clears every register in every lane to 0 and drives `err` low.
- R12: A copy writes its first source unchanged into its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be accepted |
| op_x | input | 5 | X slot opcode |
| op_y | input | 5 | Y slot opcode |
| dst_x | input | 4 | X destination register |
| dst_y_f | input | 3 | Shortened Y destination field |
| x_a | input | 4 | X first source register |
| x_a_lit | input | 1 | X first source takes the literal |
| x_b | input | 4 | X second source register |
| y_a | input | 4 | Y first source register |
| y_a_lit | input | 1 | Y first source takes the literal |
| y_b | input | 4 | Y second source register |
| literal | input | 32 | Literal word carried with the instruction |
| lane_en | input | 4 | Per-lane write enable mask |
| peek_idx | input | 4 | Register index to observe |
| peek_data | output | 128 | Register `peek_idx` of every lane, lane 0 in the low bits |
| err | output | 1 | Illegal opcode seen in the last accepted instruction |

## Verification
Two things happen in the same cycle for one instruction: the X write and the Y read. The bench provokes the collision by having X overwrite the very register that Y adds. It uses a wraparound value and a doubled operand, and then judges Y's result against sums built only from the pre-instruction contents. The write suppression of an illegal opcode is checked in the same way: the bench issues an instruction whose writes would have landed, and confirms both destinations unchanged alongside the raised flag.

// File: rtl/dvp_pkg.sv
package dvp_pkg;

    localparam int OPW = 5;
    localparam int DW  = 32;

    localparam logic [OPW-1:0] OPC_COPY    = 5'd0;
    localparam logic [OPW-1:0] OPC_ADD     = 5'd16;
    localparam logic [OPW-1:0] OPC_SHL_REV = 5'd17;
    localparam logic [OPW-1:0] OPC_AND     = 5'd18;
    localparam logic [OPW-1:0] X_LIMIT     = 5'd16;
    localparam logic [OPW-1:0] Y_LIMIT     = 5'd19;

    typedef struct packed {
        logic wr_x;
        logic wr_y;
        logic bad;
    } dvp_ctrl_t;

    typedef struct packed {
        logic [DW-1:0] xa;
        logic [DW-1:0] ya;
        logic [DW-1:0] yb;
    } dvp_operands_t;

    function automatic logic slot_x_legal(input logic [OPW-1:0] op);
        return op < X_LIMIT;
    endfunction

    function automatic logic slot_y_legal(input logic [OPW-1:0] op);
        return op < Y_LIMIT;
    endfunction

    function automatic logic slot_y_writes(input logic [OPW-1:0] op);
        return (op == OPC_COPY) || (op == OPC_ADD) ||
               (op == OPC_SHL_REV) || (op == OPC_AND);
    endfunction

    function automatic logic [DW-1:0] y_compute(input logic [OPW-1:0] op,
                                                input logic [DW-1:0] a,
                                                input logic [DW-1:0] b);
        logic [DW-1:0] r;
        case (op)
            OPC_ADD:     r = a + b;
            OPC_SHL_REV: r = b << a[4:0];
            OPC_AND:     r = a & b;
            default:     r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dvp_decode.sv
module dvp_decode
    import dvp_pkg::*;
#(
    parameter int RW = 4
) (
    input  logic              fire,
    input  logic [OPW-1:0]    op_x,
    input  logic [OPW-1:0]    op_y,
    input  logic [RW-1:0]     dst_x,
    input  logic [RW-2:0]     dst_y_f,
    output logic [RW-1:0]     dst_y,
    output dvp_ctrl_t         ctrl
);
    logic bad;

    always_comb begin
        bad       = !slot_x_legal(op_x) || !slot_y_legal(op_y);
        dst_y     = {dst_y_f, ~dst_x[0]};
        ctrl.bad  = fire && bad;
        ctrl.wr_x = fire && !bad && (op_x == OPC_COPY);
        ctrl.wr_y = fire && !bad && slot_y_writes(op_y);
    end
endmodule

// File: rtl/dvp_lane.sv
module dvp_lane
    import dvp_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int RW   = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lane_on,
    input  dvp_ctrl_t         ctrl,
    input  logic [OPW-1:0]    op_y,
    input  logic [RW-1:0]     dst_x,
    input  logic [RW-1:0]     dst_y,
    input  logic [RW-1:0]     x_a,
    input  logic              x_a_lit,
    input  logic [RW-1:0]     y_a,
    input  logic              y_a_lit,
    input  logic [RW-1:0]     y_b,
    input  logic [DW-1:0]     literal,
    input  logic [RW-1:0]     peek_idx,
    output logic [DW-1:0]     peek_word
);
    logic [DW-1:0] bank [NREGS];
    dvp_operands_t  opnd;
    logic [DW-1:0]  res_x;
    logic [DW-1:0]  res_y;

    // Every operand is sampled from the bank before the edge that commits.
    always_comb begin
        opnd.xa   = x_a_lit ? literal : bank[x_a];
        opnd.ya   = y_a_lit ? literal : bank[y_a];
        opnd.yb   = bank[y_b];
        res_x     = opnd.xa;
        res_y     = y_compute(op_y, opnd.ya, opnd.yb);
        peek_word = bank[peek_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) bank[i] <= '0;
        end else if (lane_on) begin
            if (ctrl.wr_x) bank[dst_x] <= res_x;
            if (ctrl.wr_y) bank[dst_y] <= res_y;
        end
    end
endmodule

// File: rtl/dual_valu_pair.sv
module dual_valu_pair
    import dvp_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NREGS = 16,
    localparam int RW   = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [OPW-1:0]        op_x,
    input  logic [OPW-1:0]        op_y,
    input  logic [RW-1:0]         dst_x,
    input  logic [RW-2:0]         dst_y_f,
    input  logic [RW-1:0]         x_a,
    input  logic                  x_a_lit,
    input  logic [RW-1:0]         x_b,
    input  logic [RW-1:0]         y_a,
    input  logic                  y_a_lit,
    input  logic [RW-1:0]         y_b,
    input  logic [DW-1:0]         literal,
    input  logic [LANES-1:0]      lane_en,
    input  logic [RW-1:0]         peek_idx,
    output logic [LANES*DW-1:0]   peek_data,
    output logic                  err
);
    logic      fire;
    logic      x_b_unused;
    logic [RW-1:0] dst_y;
    dvp_ctrl_t ctrl;

    assign in_ready   = !rst;
    assign fire       = in_valid && in_ready;
    // The copy is the only X operation in scope, so its second source is never read.
    assign x_b_unused = ^x_b;

    dvp_decode #(.RW(RW)) u_decode (
        .fire    (fire),
        .op_x    (op_x),
        .op_y    (op_y),
        .dst_x   (dst_x),
        .dst_y_f (dst_y_f),
        .dst_y   (dst_y),
        .ctrl    (ctrl)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            dvp_lane #(.NREGS(NREGS)) u_lane (
                .clk       (clk),
                .rst       (rst),
                .lane_on   (lane_en[l]),
                .ctrl      (ctrl),
                .op_y      (op_y),
                .dst_x     (dst_x),
                .dst_y     (dst_y),
                .x_a       (x_a),
                .x_a_lit   (x_a_lit),
                .y_a       (y_a),
                .y_a_lit   (y_a_lit),
                .y_b       (y_b),
                .literal   (literal),
                .peek_idx  (peek_idx),
                .peek_word (peek_data[l*DW +: DW])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= ctrl.bad;
    end
endmodule

// File: rtl/dvp_checker.sv
module dvp_checker #(
    parameter int LANES = 4,
    parameter int RW    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic [4:0]         op_x,
    input logic [4:0]         op_y,
    input logic [LANES-1:0]   lane_en,
    input logic [RW-1:0]      peek_idx,
    input logic [LANES*32-1:0] peek_data,
    input logic               err
);
    assert_ready_R10: assert property (@(posedge clk) disable iff (rst) in_ready);

    assert_bad_x_flags_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && op_x >= 5'd16) |=> err);

    assert_bad_y_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && op_y >= 5'd19) |=> err);

    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !err);

    assert_bad_x_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_x >= 5'd16) |=> (!$stable(peek_idx) || $stable(peek_data)));

    assert_masked_off_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_en == '0) |=> (!$stable(peek_idx) || $stable(peek_data)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!$stable(peek_idx) || $stable(peek_data)));
endmodule

bind dual_valu_pair dvp_checker #(.LANES(LANES), .RW(RW)) u_dvp_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op_x      (op_x),
    .op_y      (op_y),
    .lane_en   (lane_en),
    .peek_idx  (peek_idx),
    .peek_data (peek_data),
    .err       (err)
);

// File: tb/dual_valu_pair_bench.sv
module dual_valu_pair_bench;
    localparam int LANES = 4;
    localparam int NREGS = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [4:0]         op_x = '0, op_y = '0;
    logic [3:0]         dst_x = '0;
    logic [2:0]         dst_y_f = '0;
    logic [3:0]         x_a = '0, x_b = '0, y_a = '0, y_b = '0;
    logic               x_a_lit = 1'b0, y_a_lit = 1'b0;
    logic [31:0]        literal = '0;
    logic [LANES-1:0]   lane_en = '0;
    logic [3:0]         peek_idx = '0;
    logic [LANES*32-1:0] peek_data;
    logic               err;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    dual_valu_pair #(.LANES(LANES), .NREGS(NREGS)) u_dual_valu_pair (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .op_x(op_x), .op_y(op_y), .dst_x(dst_x), .dst_y_f(dst_y_f),
        .x_a(x_a), .x_a_lit(x_a_lit), .x_b(x_b), .y_a(y_a), .y_a_lit(y_a_lit),
        .y_b(y_b), .literal(literal), .lane_en(lane_en), .peek_idx(peek_idx),
        .peek_data(peek_data), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic peek_chk(input string req, input int idx, input int lane, input logic [31:0] exp);
        peek_idx = idx[3:0];
        #0.5;
        check(req, peek_data[lane*32 +: 32], exp);
    endtask

    // Drive at the falling edge, commit at the rising edge, sample after it.
    task automatic issue(input logic [4:0] ox, input logic [4:0] oy,
                         input int dx, input int dyf,
                         input int xa, input logic xl, input int ya, input logic yl, input int yb,
                         input logic [31:0] lit, input logic [LANES-1:0] mask);
        @(negedge clk);
        in_valid = 1'b1; op_x = ox; op_y = oy; dst_x = dx[3:0]; dst_y_f = dyf[2:0];
        x_a = xa[3:0]; x_a_lit = xl; x_b = 4'd0; y_a = ya[3:0]; y_a_lit = yl; y_b = yb[3:0];
        literal = lit; lane_en = mask;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic load(input int r, input logic [31:0] val, input logic [LANES-1:0] mask);
        issue(5'd0, 5'd1, r, 0, 0, 1'b1, 0, 1'b0, 0, val, mask);
    endtask

    task automatic t_reset;
        check("R10 ready", {31'd0, in_ready}, 32'd1);
        check("R11 err", {31'd0, err}, 32'd0);
        for (int r = 0; r < NREGS; r++)
            for (int l = 0; l < LANES; l++) begin
                peek_idx = r[3:0];
                #0.1;
                if (peek_data[l*32 +: 32] !== 32'd0) check("R11 reg", peek_data[l*32 +: 32], 32'd0);
            end
        check("R11 regs zero", {31'd0, peek_data === '0}, 32'd1);
    endtask

    task automatic t_literal_copy;
        // X copies literal to r2, Y copies literal too; field 5 with even dst_x -> r11
        issue(5'd0, 5'd0, 2, 5, 0, 1'b1, 0, 1'b1, 0, 32'h1234_5678, 4'hF);
        peek_chk("R8 R12 x literal", 2, 0, 32'h1234_5678);
        peek_chk("R4 R8 y literal to r11", 11, 3, 32'h1234_5678);
        check("R10 err low", {31'd0, err}, 32'd0);
    endtask

    task automatic t_read_before_write;
        load(0, 32'd1, 4'hF);
        load(2, 32'hFFFF_FFFF, 4'hF);
        // X writes 0 to r2 while Y adds old r2 + r0 into r1
        issue(5'd0, 5'd16, 2, 0, 0, 1'b1, 2, 1'b0, 0, 32'd0, 4'hF);
        peek_chk("R1 x wrote r2", 2, 1, 32'd0);
        peek_chk("R1 R5 wrap of old r2", 1, 1, 32'd0);
        load(2, 32'd100, 4'hF);
        issue(5'd0, 5'd16, 2, 0, 0, 1'b1, 2, 1'b0, 2, 32'd0, 4'hF);
        peek_chk("R1 doubled old r2", 1, 2, 32'd200);
        peek_chk("R1 x wrote r2 again", 2, 2, 32'd0);
    endtask

    task automatic t_shift_and;
        load(4, 32'd3, 4'hF);
        load(5, 32'h0000_00F1, 4'hF);
        issue(5'd0, 5'd17, 6, 3, 0, 1'b1, 4, 1'b0, 5, 32'h0000_00AB, 4'hF);
        peek_chk("R6 shift by 3", 7, 0, 32'h0000_0788);
        load(4, 32'd33, 4'hF);
        issue(5'd0, 5'd17, 6, 3, 0, 1'b1, 4, 1'b0, 5, 32'h0000_00AB, 4'hF);
        peek_chk("R6 shift amount 33", 7, 0, 32'h0000_01E2);
        // X copies register r5 into r6, Y ANDs literal with r5
        issue(5'd0, 5'd18, 6, 3, 5, 1'b0, 0, 1'b1, 5, 32'hFF00_FF0F, 4'hF);
        peek_chk("R7 and", 7, 1, 32'h0000_0001);
        peek_chk("R12 register copy", 6, 1, 32'h0000_00F1);
    endtask

    task automatic t_parity;
        // odd dst_x=3, field 2 -> r4
        issue(5'd0, 5'd0, 3, 2, 0, 1'b1, 5, 1'b0, 0, 32'h33, 4'hF);
        peek_chk("R4 odd x dest", 3, 2, 32'h33);
        peek_chk("R4 y dest r4", 4, 2, 32'hF1);
    endtask

    task automatic t_illegal;
        issue(5'd16, 5'd16, 2, 0, 0, 1'b1, 2, 1'b0, 2, 32'h77, 4'hF);
        check("R2 err on x16", {31'd0, err}, 32'd1);
        peek_chk("R2 r2 kept", 2, 0, 32'd0);
        peek_chk("R2 r1 kept", 1, 0, 32'd200);
        @(negedge clk);
        check("R10 err one cycle", {31'd0, err}, 32'd0);
        issue(5'd0, 5'd19, 2, 0, 0, 1'b1, 2, 1'b0, 2, 32'h77, 4'hF);
        check("R3 err on y19", {31'd0, err}, 32'd1);
        peek_chk("R3 x write suppressed", 2, 3, 32'd0);
        issue(5'd5, 5'd9, 2, 0, 0, 1'b1, 2, 1'b0, 2, 32'h77, 4'hF);
        check("R2 R3 reserved no err", {31'd0, err}, 32'd0);
        peek_chk("R2 reserved x no write", 2, 3, 32'd0);
        peek_chk("R3 reserved y no write", 1, 3, 32'd200);
    endtask

    task automatic t_mask;
        load(9, 32'h55, 4'hF);
        for (int l = 0; l < LANES; l++) load(8, 32'(10 * (l + 1)), LANES'(1 << l));
        issue(5'd0, 5'd16, 10, 4, 0, 1'b1, 8, 1'b0, 8, 32'hC0, 4'b0101);
        peek_chk("R9 lane0 sum", 9, 0, 32'd20);
        peek_chk("R9 lane2 sum", 9, 2, 32'd60);
        peek_chk("R9 lane1 kept", 9, 1, 32'h55);
        peek_chk("R9 lane3 kept", 9, 3, 32'h55);
        peek_chk("R9 lane0 x", 10, 0, 32'hC0);
        peek_chk("R9 lane3 x kept", 10, 3, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 ready low in reset", {31'd0, in_ready}, 32'd0);
        rst = 1'b0;
        #1;
        t_reset();
        t_literal_copy();
        t_read_before_write();
        t_shift_and();
        t_parity();
        t_illegal();
        t_mask();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #40000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule